// File: doc/BRIEF.md
# Two-Stage Pipelined Stream CRC

This block computes a running CRC over a stream of data words. The words arrive with a valid/ready handshake and a flag marking the final word of each packet. The CRC update is split in two, with a register after each half. The first half works out the contribution of the incoming word alone, as though the CRC state were zero. The second half advances the stored packet state across one word of zeros and folds in that registered contribution. Because CRC arithmetic is linear over GF(2), the two halves together give exactly the bit-serial result. Each half is only about half of the original logic depth.

Every accepted word yields exactly one output beat. That beat carries the CRC of its packet up to and including that word, with the final XOR applied. The word's last flag travels alongside it through both stages, so the beat flagged last holds the finished packet CRC.

Both stages are stall-gated. A stage loads only when it is empty or when the stage after it hands its beat on. Backpressure on the output therefore stops the pipe without losing or altering any beat. Once a beat flagged last has entered the accumulating stage, the state is seeded again from the initial value for the next packet. The polynomial, the initial value and the final XOR are parameters. The data width may be up to 64 bits and the CRC width up to 32 bits. Bits are processed most significant bit first, with no reflection.

Top module: `crc_pipe`

## Requirements
- R1: While reset is low at a clock edge, both stages are emptied: after that edge out_valid is 0 and in_ready is 1. Reset clears only the valid and seed state, not the data registers.
- R2: Each input word accepted (in_valid and in_ready both 1 at a clock edge) produces exactly one output beat, in order. Its out_crc equals (S XOR XOROUT). S is the bit-serial, MSB-first CRC state after all words of the current packet so far. Each bit step sets fb = state[CRC_W-1] ^ bit, shifts the state left by one, and XORs in POLY when fb is 1. The state starts from INIT.
- R3: With out_ready held at 1, a word accepted at clock edge N makes out_valid 1 after edge N+1 and not before: two register stages of latency.
- R4: out_last of each output beat equals the in_last of the word that produced it.
- R5: After a word with in_last = 1, the next accepted word starts a new packet whose state is seeded from INIT, so packets are independent.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_crc and out_last hold their values at the next edge.
- R7: in_ready is 1 whenever out_valid is 0. With out_ready held at 0, exactly two words are absorbed before in_ready drops, and none is lost.
- R8: With out_ready held at 1, the block accepts one word on every cycle; in_ready never drops.
- R9: in_data and in_last have no effect when they are not accepted (idle cycles between words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take the input word this cycle |
| in_data | input | DATA_W | Input data word |
| in_last | input | 1 | Input word is the final word of its packet |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat this cycle |
| out_crc | output | CRC_W | Running packet CRC with final XOR applied |
| out_last | output | 1 | Output beat belongs to the final word of a packet |

## Verification
The CRC is exercised with single-word packets, which separate seeding from accumulation, and with multi-word packets of several lengths, which check the state carried between words and the re-seed after a last word. Packets are sent back to back, which checks full throughput, and with idle gaps carrying random data and flags, which shows that words not accepted have no effect. The output ready is driven always high, alternating, in long low bursts, pseudo-randomly, and held low. These patterns tell apart stall gating, hold-stable behaviour, the two-beat absorption limit and the exact two-cycle latency. Every beat is compared with an independent bit-serial model.

// File: rtl/crc_pipe_pkg.sv
package crc_pipe_pkg;

    // Advance a CRC state of cw bits over nbits of data, MSB first.
    // Either operand may be zero to get the state-only or data-only part.
    function automatic logic [31:0] crc_advance(
        input logic [31:0] state,
        input logic [63:0] data,
        input int          nbits,
        input int          cw,
        input logic [31:0] poly
    );
        logic [31:0] acc;
        logic [31:0] pal;
        logic [63:0] din;
        logic        fb;
        acc = state << (32 - cw);
        pal = poly << (32 - cw);
        din = data << (64 - nbits);
        for (int i = 0; i < 64; i++) begin
            if (i < nbits) begin
                fb  = acc[31] ^ din[63];
                acc = acc << 1;
                din = din << 1;
                if (fb) acc = acc ^ pal;
            end
        end
        return acc >> (32 - cw);
    endfunction

endpackage

// File: rtl/crc_pipe_fold.sv
module crc_pipe_fold #(
    parameter int              DATA_W = 16,
    parameter int              CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              take,
    output logic              st_valid,
    output logic [CRC_W-1:0]  st_part,
    output logic              st_last
);
    import crc_pipe_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic [CRC_W-1:0] part;
    } fold_t;

    fold_t       fold_d, fold_q;
    logic [31:0] part_full;

    always_comb begin
        fold_d    = fold_q;
        in_ready  = !fold_q.valid || take;
        part_full = crc_advance(32'd0, 64'(in_data), DATA_W, CRC_W, 32'(POLY));
        if (in_ready) begin
            fold_d.valid = in_valid;
            if (in_valid) begin
                fold_d.last = in_last;
                fold_d.part = part_full[CRC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fold_q.valid <= 1'b0;
        else        fold_q.valid <= fold_d.valid;
        fold_q.last <= fold_d.last;
        fold_q.part <= fold_d.part;
    end

    assign st_valid = fold_q.valid;
    assign st_part  = fold_q.part;
    assign st_last  = fold_q.last;

endmodule

// File: rtl/crc_pipe_accum.sv
module crc_pipe_accum #(
    parameter int               DATA_W = 16,
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
    parameter logic [CRC_W-1:0] XOROUT = 16'hA5A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [CRC_W-1:0] st_part,
    input  logic             st_last,
    output logic             advance,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [CRC_W-1:0] out_crc,
    output logic             out_last
);
    import crc_pipe_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             last;
        logic             seed;
        logic [CRC_W-1:0] crc;
    } acc_t;

    acc_t             acc_d, acc_q;
    logic [CRC_W-1:0] base;
    logic [31:0]      moved;

    always_comb begin
        acc_d   = acc_q;
        advance = !acc_q.valid || out_ready;
        base    = acc_q.seed ? INIT : acc_q.crc;
        moved   = crc_advance(32'(base), 64'd0, DATA_W, CRC_W, 32'(POLY));
        if (advance) begin
            acc_d.valid = st_valid;
            if (st_valid) begin
                acc_d.crc  = moved[CRC_W-1:0] ^ st_part;
                acc_d.last = st_last;
                acc_d.seed = st_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q.valid <= 1'b0;
            acc_q.seed  <= 1'b1;
        end else begin
            acc_q.valid <= acc_d.valid;
            acc_q.seed  <= acc_d.seed;
        end
        acc_q.last <= acc_d.last;
        acc_q.crc  <= acc_d.crc;
    end

    assign out_valid = acc_q.valid;
    assign out_crc   = acc_q.crc ^ XOROUT;
    assign out_last  = acc_q.last;

endmodule

// File: rtl/crc_pipe.sv
module crc_pipe #(
    parameter int               DATA_W = 16,
    parameter int               CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY   = 16'h1021,
    parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
    parameter logic [CRC_W-1:0] XOROUT = 16'hA5A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CRC_W-1:0]  out_crc,
    output logic              out_last
);
    logic             mid_valid;
    logic [CRC_W-1:0] mid_part;
    logic             mid_last;
    logic             mid_take;

    crc_pipe_fold #(
        .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)
    ) u_fold (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .take(mid_take),
        .st_valid(mid_valid), .st_part(mid_part), .st_last(mid_last)
    );

    crc_pipe_accum #(
        .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY),
        .INIT(INIT), .XOROUT(XOROUT)
    ) u_accum (
        .clk(clk), .rst_n(rst_n),
        .st_valid(mid_valid), .st_part(mid_part), .st_last(mid_last),
        .advance(mid_take), .out_ready(out_ready),
        .out_valid(out_valid), .out_crc(out_crc), .out_last(out_last)
    );

endmodule

// File: rtl/crc_pipe_checks.sv
module crc_pipe_checks #(
    parameter int CRC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CRC_W-1:0] out_crc,
    input logic             out_last
);
    // R1: a reset edge leaves both stages empty
    assert_reset_empty_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R3: a beat appearing on the output was accepted two edges earlier
    assert_two_stage_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

    // R6: stalled output holds valid, CRC and last flag
    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_crc) && $stable(out_last)));

    // R7: an empty output stage never blocks the input
    assert_ready_when_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

endmodule

bind crc_pipe crc_pipe_checks #(.CRC_W(CRC_W)) u_checks (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_crc(out_crc), .out_last(out_last)
);

// File: tb/crc_pipe_test.sv
module crc_pipe_test;
    localparam int               DATA_W = 16;
    localparam int               CRC_W  = 16;
    localparam logic [CRC_W-1:0] POLY   = 16'h1021;
    localparam logic [CRC_W-1:0] INIT   = 16'hFFFF;
    localparam logic [CRC_W-1:0] XOROUT = 16'hA5A5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_last = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [CRC_W-1:0]  out_crc;
    logic              out_last;

    always #5 clk = ~clk;

    crc_pipe #(
        .DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT), .XOROUT(XOROUT)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_crc(out_crc), .out_last(out_last)
    );

    typedef struct {
        logic [CRC_W-1:0] crc;
        logic             last;
        string            tag;
    } exp_t;

    exp_t             sb[$];
    int               checks = 0;
    int               fails = 0;
    int               ready_mode = 0;
    int               waits = 0;
    logic [CRC_W-1:0] run = '0;
    bit               fresh = 1'b1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [CRC_W-1:0] ref_word(input logic [CRC_W-1:0] c0,
                                                  input logic [DATA_W-1:0] d0);
        logic [CRC_W-1:0]  c;
        logic [DATA_W-1:0] d;
        logic              fb;
        c = c0;
        d = d0;
        for (int b = 0; b < DATA_W; b++) begin
            fb = c[CRC_W-1] ^ d[DATA_W-1];
            c  = c << 1;
            d  = d << 1;
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    // output ready patterns
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk); #1;
            rc++;
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = rc[0];
                2: out_ready = (rc % 8) >= 5;
                3: out_ready = (($urandom % 3) != 0);
                default: out_ready = 1'b0;
            endcase
        end
    end

    // called just after a rising edge
    task automatic send_beat(input logic [DATA_W-1:0] d, input logic l, input string tag);
        exp_t e;
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            waits++;
        end
        if (fresh) run = INIT;
        run    = ref_word(run, d);
        fresh  = l;
        e.crc  = run ^ XOROUT;
        e.last = l;
        e.tag  = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_data  = DATA_W'($urandom);
        in_last  = 1'($urandom);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            in_data = DATA_W'($urandom);
            in_last = 1'($urandom);
        end
    endtask

    task automatic send_packet(input int len, input int gaps, input string tag);
        for (int i = 0; i < len; i++) begin
            send_beat(DATA_W'($urandom), (i == len - 1), tag);
            if (gaps != 0) idle(1 + (i % 3));
        end
    endtask

    // scoreboard monitor and stall-hold check
    initial begin
        exp_t             e;
        bit               was_stall = 1'b0;
        logic [CRC_W-1:0] held_crc = '0;
        logic             held_last = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (was_stall) begin
                    check(out_valid, "R6", "valid dropped while stalled", 64'(out_valid), 64'd1);
                    check(out_crc == held_crc, "R6", "crc changed while stalled",
                          64'(out_crc), 64'(held_crc));
                    check(out_last == held_last, "R6", "last changed while stalled",
                          64'(out_last), 64'(held_last));
                end
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R2", "beat with nothing expected", 64'(out_crc), 64'd0);
                    end else begin
                        e = sb.pop_front();
                        check(out_crc == e.crc, e.tag, "crc", 64'(out_crc), 64'(e.crc));
                        check(out_last == e.last, "R4", "last flag", 64'(out_last), 64'(e.last));
                    end
                end
                was_stall = out_valid && !out_ready;
                held_crc  = out_crc;
                held_last = out_last;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int w0;
        in_data = DATA_W'($urandom);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
        @(posedge clk); #1;

        // R3: single-word packet, exact two-stage latency
        fork
            send_beat(16'h1234, 1'b1, "R3");
            begin
                @(negedge clk);
                @(negedge clk);
                check(!out_valid, "R3", "valid one edge after accept", 64'(out_valid), 64'd0);
                @(negedge clk);
                check(out_valid, "R3", "valid two edges after accept", 64'(out_valid), 64'd1);
            end
        join
        idle(3);

        // R2 / R5: packets of varied length, back to back
        send_packet(1, 0, "R5");
        send_packet(3, 0, "R2");
        send_packet(7, 0, "R5");

        // R8: full throughput with ready held high
        w0 = waits;
        send_packet(12, 0, "R8");
        check(waits == w0, "R8", "input stalls with ready high", 64'(waits - w0), 64'd0);
        idle(4);

        // R7: output blocked, exactly two words absorbed
        ready_mode = 4;
        @(posedge clk); #1;
        w0 = waits;
        send_beat(DATA_W'($urandom), 1'b0, "R7");
        send_beat(DATA_W'($urandom), 1'b0, "R7");
        check(waits == w0, "R7", "two words absorbed without stall", 64'(waits - w0), 64'd0);
        fork
            send_beat(DATA_W'($urandom), 1'b1, "R7");
            begin
                repeat (4) @(negedge clk);
                check(!in_ready, "R7", "in_ready with both stages full", 64'(in_ready), 64'd0);
                check(out_valid, "R7", "out_valid while blocked", 64'(out_valid), 64'd1);
                ready_mode = 0;
            end
        join
        check(waits > w0, "R7", "third word stalled", 64'(waits - w0), 64'd1);
        idle(4);

        // R6: backpressure patterns
        ready_mode = 1;
        send_packet(5, 0, "R6");
        send_packet(4, 1, "R6");
        ready_mode = 2;
        send_packet(9, 0, "R6");
        send_packet(2, 1, "R5");
        ready_mode = 3;
        for (int p = 0; p < 6; p++) send_packet(1 + p * 2, p % 2, "R2");

        // R9: gaps carrying random data and last flags
        ready_mode = 0;
        send_packet(6, 1, "R9");
        send_packet(3, 1, "R9");

        for (int t = 0; t < 200 && sb.size() != 0; t++) @(posedge clk);
        #1;
        check(sb.size() == 0, "R2", "results outstanding", 64'(sb.size()), 64'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule